// File: doc/BRIEF.md
# Accumulator Decimal Adjust and Carry Flag Unit

This unit performs the accumulator operations of an 8-bit processor that touch the carry flag without using a second operand. It takes the accumulator and the 8-bit flag byte and applies one of four operations:

- decimal adjust after a binary add or subtract of two packed-BCD bytes;
- set carry;
- complement carry;
- a pass-through that returns both inputs unchanged.

The decimal adjust uses two threshold tests instead of a lookup table. The set-carry and complement-carry operations fill the two undocumented flag bits (3 and 5) from the old flags ORed with the accumulator, as on the NMOS-era parts of this family.

The result is captured in one output register stage. An input valid strobe is echoed on the output one cycle later, so a pipeline or a bench can pair each request with its answer. The flag byte layout is, from bit 7 down to bit 0: sign, zero, undocumented copy Y, half carry, undocumented copy X, parity/overflow, subtract, carry.

Top module: `accadj_unit`

## Requirements
- R1: In decimal adjust (op = 2'b00), a low step of 0x06 is applied when the incoming half-carry flag (bit 4) is 1 or the accumulator's low nibble is greater than 9.
- R2: In decimal adjust, a high step of 0x60 is applied when the incoming carry flag (bit 0) is 1 or the accumulator is greater than 0x99.
- R3: In decimal adjust, the steps are subtracted modulo 256 when the incoming subtract flag (bit 1) is 1, and added modulo 256 when it is 0.
- R4: After decimal adjust, carry (bit 0) is the old carry ORed with (accumulator > 0x99), and subtract (bit 1) keeps its old value.
- R5: After decimal adjust, half carry (bit 4) equals bit 4 of (old accumulator XOR new accumulator).
- R6: After decimal adjust, the following flags are taken from the new accumulator:
  - sign (bit 7) is bit 7 of the result;
  - zero (bit 6) is 1 when the result is 0;
  - Y (bit 5) and X (bit 3) copy result bits 5 and 3;
  - parity (bit 2) is 1 when the result has an even number of ones.
- R7: Set carry (op = 2'b01) gives carry 1, half carry 0 and subtract 0, and keeps sign, zero and parity.
- R8: Complement carry (op = 2'b10) inverts carry, copies the old carry into half carry, clears subtract, and keeps sign, zero and parity.
- R9: For set carry and complement carry, bits 5 and 3 of the new flags equal (old flags OR accumulator) AND 0x28.
- R10: Set carry and complement carry return the accumulator unchanged.
- R11: Pass-through (op = 2'b11) returns both the accumulator and the flags unchanged.
- R12: A request with in_valid high produces its result, with out_valid high, on the next rising clock edge. When in_valid is low, out_valid is 0 and the result outputs keep their values.
- R13: While rst is high at a clock edge, out_valid, acc_out and flags_out are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 decimal adjust, 01 set carry, 10 complement carry, 11 pass-through |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Flag byte S Z Y H X P N C (bit 7 down to bit 0) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
The unit keeps no state besides its output register, so any wrong decision inside it shows up at acc_out or flags_out on the cycle after the request. An off-by-one in either threshold shows up only near the nibble value 9 or the byte value 0x99. The bench therefore sweeps every accumulator value under all eight subtract/half/carry combinations and compares each result against its own model. A mistake in which flag is kept, cleared or copied by the carry operations shows up as a single wrong bit. Directed flag patterns with every bit set and every bit clear expose such a mistake in one request.

// File: rtl/accadj_pkg.sv
package accadj_pkg;

    localparam int unsigned ACC_W   = 8;
    localparam int unsigned NIB_W   = ACC_W / 2;
    localparam int unsigned OP_W    = 2;

    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [NIB_W-1:0] nib_t;

    // Flag byte, most significant bit first
    typedef struct packed {
        logic s;
        logic z;
        logic y;
        logic h;
        logic x;
        logic p;
        logic n;
        logic c;
    } flag_t;

    typedef enum logic [OP_W-1:0] {
        OP_DEC_ADJ  = 2'b00,
        OP_SET_CY   = 2'b01,
        OP_CPL_CY   = 2'b10,
        OP_PASS     = 2'b11
    } accadj_op_e;

    localparam nib_t DIGIT_MAX  = nib_t'(9);
    localparam acc_t BYTE_LIMIT = acc_t'(8'h99);
    localparam acc_t LOW_STEP   = acc_t'(8'h06);
    localparam acc_t HIGH_STEP  = acc_t'(8'h60);

    // 1 when the byte holds an even number of ones
    function automatic logic even_parity(input acc_t v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/accadj_result_flags.sv
module accadj_result_flags
    import accadj_pkg::*;
(
    input  acc_t value,
    output logic sign_o,
    output logic zero_o,
    output logic ybit_o,
    output logic xbit_o,
    output logic par_o
);
    always_comb begin
        sign_o = value[ACC_W-1];
        zero_o = (value == '0);
        ybit_o = value[5];
        xbit_o = value[3];
        par_o  = even_parity(value);
    end
endmodule

// File: rtl/accadj_daa_core.sv
module accadj_daa_core
    import accadj_pkg::*;
(
    input  acc_t  acc_i,
    input  logic  n_i,
    input  logic  h_i,
    input  logic  c_i,
    output acc_t  acc_o,
    output flag_t flags_o
);
    logic low_fix, high_fix, over_lim;
    acc_t step, adj;
    logic r_s, r_z, r_y, r_x, r_p;

    always_comb begin
        over_lim = (acc_i > BYTE_LIMIT);
        low_fix  = h_i | (acc_i[NIB_W-1:0] > DIGIT_MAX);
        high_fix = c_i | over_lim;
        step     = (low_fix ? LOW_STEP : '0) | (high_fix ? HIGH_STEP : '0);
        adj      = n_i ? (acc_i - step) : (acc_i + step);
    end

    accadj_result_flags u_rf (
        .value  (adj),
        .sign_o (r_s),
        .zero_o (r_z),
        .ybit_o (r_y),
        .xbit_o (r_x),
        .par_o  (r_p)
    );

    always_comb begin
        acc_o     = adj;
        flags_o.s = r_s;
        flags_o.z = r_z;
        flags_o.y = r_y;
        flags_o.h = acc_i[NIB_W] ^ adj[NIB_W];
        flags_o.x = r_x;
        flags_o.p = r_p;
        flags_o.n = n_i;
        flags_o.c = c_i | over_lim;
    end
endmodule

// File: rtl/accadj_carry_core.sv
module accadj_carry_core
    import accadj_pkg::*;
(
    input  logic  invert_i,   // 0: set carry, 1: complement carry
    input  logic  s_i,
    input  logic  z_i,
    input  logic  p_i,
    input  logic  c_i,
    input  logic  fy_i,
    input  logic  fx_i,
    input  logic  ay_i,
    input  logic  ax_i,
    output flag_t flags_o
);
    always_comb begin
        flags_o.s = s_i;
        flags_o.z = z_i;
        flags_o.p = p_i;
        flags_o.y = fy_i | ay_i;
        flags_o.x = fx_i | ax_i;
        flags_o.n = 1'b0;
        flags_o.c = invert_i ? ~c_i : 1'b1;
        flags_o.h = invert_i ? c_i : 1'b0;
    end
endmodule

// File: rtl/accadj_unit.sv
module accadj_unit
    import accadj_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] flags_in,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc_out,
    output logic [ACC_W-1:0] flags_out
);
    flag_t      fin;
    accadj_op_e sel;
    acc_t       daa_acc;
    flag_t      daa_flags, cy_flags;
    acc_t       nxt_acc;
    flag_t      nxt_flags;

    assign fin = flag_t'(flags_in);
    assign sel = accadj_op_e'(op);

    accadj_daa_core u_daa (
        .acc_i   (acc_in),
        .n_i     (fin.n),
        .h_i     (fin.h),
        .c_i     (fin.c),
        .acc_o   (daa_acc),
        .flags_o (daa_flags)
    );

    accadj_carry_core u_cy (
        .invert_i (op[1]),
        .s_i      (fin.s),
        .z_i      (fin.z),
        .p_i      (fin.p),
        .c_i      (fin.c),
        .fy_i     (fin.y),
        .fx_i     (fin.x),
        .ay_i     (acc_in[5]),
        .ax_i     (acc_in[3]),
        .flags_o  (cy_flags)
    );

    always_comb begin
        nxt_acc   = acc_in;
        nxt_flags = fin;
        case (sel)
            OP_DEC_ADJ: begin
                nxt_acc   = daa_acc;
                nxt_flags = daa_flags;
            end
            OP_SET_CY, OP_CPL_CY: nxt_flags = cy_flags;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            acc_out   <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_out   <= nxt_acc;
                flags_out <= nxt_flags;
            end
        end
    end
endmodule

// File: rtl/accadj_unit_chk.sv
module accadj_unit_chk
    import accadj_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  op,
    input logic [ACC_W-1:0] acc_in,
    input logic [ACC_W-1:0] flags_in,
    input logic             out_valid,
    input logic [ACC_W-1:0] acc_out,
    input logic [ACC_W-1:0] flags_out
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
        seen |-> (out_valid == $past(in_valid)));

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (seen && !in_valid) |=> ($stable(acc_out) && $stable(flags_out)));

    p_acc_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 2'b01 || op == 2'b10)) |=> (acc_out == $past(acc_in)));

    p_set_cy_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b01) |=>
            (flags_out[0] && !flags_out[1] && !flags_out[4]));

    p_cpl_cy_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10) |=>
            (flags_out[0] == !$past(flags_in[0]) && flags_out[4] == $past(flags_in[0])
             && !flags_out[1]));

    p_pass_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b11) |=>
            (acc_out == $past(acc_in) && flags_out == $past(flags_in)));

    p_daa_n_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00) |=> (flags_out[1] == $past(flags_in[1])));

    p_daa_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00) |=> (flags_out[6] == (acc_out == '0)));
endmodule

bind accadj_unit accadj_unit_chk u_chk (.*);

// File: tb/accadj_unit_test.sv
module accadj_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [1:0] op;
    logic [7:0] acc_in, flags_in;
    logic       out_valid;
    logic [7:0] acc_out, flags_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    accadj_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .acc_in(acc_in), .flags_in(flags_in),
        .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out)
    );

    // {op, acc, flags, expected acc, expected flags}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b00, 8'h3C, 8'h00, 8'h42, 8'h14},
        {2'b00, 8'h9A, 8'h00, 8'h00, 8'h55},
        {2'b00, 8'h1F, 8'h12, 8'h19, 8'h0A},
        {2'b00, 8'h99, 8'h01, 8'hF9, 8'hAD},
        {2'b00, 8'h00, 8'h03, 8'hA0, 8'hA7},
        {2'b01, 8'h28, 8'h00, 8'h28, 8'h29},
        {2'b01, 8'h00, 8'hFF, 8'h00, 8'hED},
        {2'b10, 8'h00, 8'h01, 8'h00, 8'h10},
        {2'b10, 8'h08, 8'h82, 8'h08, 8'h89},
        {2'b11, 8'h5A, 8'h3C, 8'h5A, 8'h3C}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent model: returns {acc, flags}
    function automatic logic [15:0] model(input logic [1:0] o, input logic [7:0] a,
                                          input logic [7:0] f);
        int v, adj, ones;
        logic [7:0] r, nf;
        v = a;
        if (o == 2'b00) begin
            adj = 0;
            if (f[4] || (v % 16) >= 10) adj += 6;
            if (f[0] || v >= 154) adj += 96;
            v = f[1] ? v - adj : v + adj;
            r = v[7:0];
            ones = 0;
            for (int i = 0; i < 8; i++) ones += r[i];
            nf = 8'h00;
            nf[7] = r[7];
            nf[6] = (r == 8'h00);
            nf[5] = r[5];
            nf[4] = a[4] ^ r[4];
            nf[3] = r[3];
            nf[2] = (ones % 2 == 0);
            nf[1] = f[1];
            nf[0] = f[0] | (a >= 8'h9A);
            return {r, nf};
        end else if (o == 2'b11) begin
            return {a, f};
        end else begin
            nf = (f & 8'hC4) | ((f | a) & 8'h28);
            if (o == 2'b01) nf[0] = 1'b1;
            else begin
                nf[0] = ~f[0];
                nf[4] = f[0];
            end
            return {a, nf};
        end
    endfunction

    task automatic run(input logic [1:0] o, input logic [7:0] a, input logic [7:0] f);
        @(negedge clk);
        in_valid = 1'b1; op = o; acc_in = a; flags_in = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] e;
        logic [7:0]  ha, hf;
        rst = 1'b1; in_valid = 1'b0; op = 2'b00; acc_in = 8'h00; flags_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && acc_out == 0 && flags_out == 0, "R13 reset",
              {out_valid, acc_out, flags_out}, 0);
        rst = 1'b0;

        // Table of directed vectors
        for (int k = 0; k < NVEC; k++) begin
            run(VEC[k][33:32], VEC[k][31:24], VEC[k][23:16]);
            check(out_valid, "R12 valid", out_valid, 1);
            check(acc_out == VEC[k][15:8], "R1/R2/R3/R10/R11 acc", acc_out, VEC[k][15:8]);
            check(flags_out == VEC[k][7:0], "R4/R5/R6/R7/R8/R9 flags", flags_out, VEC[k][7:0]);
        end

        // Hold when idle: R12
        ha = acc_out; hf = flags_out;
        acc_in = 8'h77; flags_in = 8'hFF; op = 2'b00;
        @(negedge clk);
        check(!out_valid && acc_out == ha && flags_out == hf, "R12 hold",
              {out_valid, acc_out, flags_out}, {1'b0, ha, hf});

        // Exhaustive decimal adjust over N, H, C: R1 R2 R3 R4 R5 R6
        for (int nhc = 0; nhc < 8; nhc++) begin
            for (int a = 0; a < 256; a++) begin
                logic [7:0] f;
                f = {3'b101, nhc[1], 1'b0, 1'b1, nhc[2], nhc[0]};
                run(2'b00, a[7:0], f);
                e = model(2'b00, a[7:0], f);
                check({acc_out, flags_out} == e, "R1_R2_R3_R4_R5_R6 sweep",
                      {acc_out, flags_out}, e);
            end
        end

        // Carry operations over flag/accumulator patterns: R7 R8 R9 R10
        for (int o = 1; o < 3; o++) begin
            for (int p = 0; p < 64; p++) begin
                logic [7:0] a, f;
                a = {p[5], 1'b0, p[4], 1'b0, p[3], 3'b101};
                f = {p[2], p[1], p[0], p[5], p[4], p[3], p[0], p[2]};
                run(o[1:0], a, f);
                e = model(o[1:0], a, f);
                check({acc_out, flags_out} == e, "R7_R8_R9_R10 sweep",
                      {acc_out, flags_out}, e);
            end
        end

        // Pass-through: R11
        run(2'b11, 8'hA5, 8'h5A);
        check(acc_out == 8'hA5 && flags_out == 8'h5A, "R11 pass",
              {acc_out, flags_out}, 16'hA55A);

        // Reset mid-stream: R13
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!out_valid && acc_out == 0 && flags_out == 0, "R13 reset again",
              {out_valid, acc_out, flags_out}, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule